// File: doc/BRIEF.md
# Microcode ROM Sequencer

This block serves instructions that the regular decoder cannot expand on its own: flows longer than the four-uop decoder limit, repeated string-style moves, and rarely used legacy instructions that are kept out of the fast decoders even when they are short. A request names an entry address in a small internal micro-ROM and carries a repeat count. The sequencer then walks the ROM and presents one group of three uop slots per cycle on a valid/ready output. Each group has a per-slot valid mask and a last-group flag.

Every ROM word holds three uop slots, their valid bits, an end-of-flow bit, a jump condition and a jump target. A loop down-counter is loaded from the repeat count. A conditional micro-jump in the loop body branches back while iterations remain. A guard word at the head of a looping flow skips the body entirely when the count is zero. While a flow is in progress the sequencer owns the uop output and raises a stall to the regular decoders. No new request is taken until the final group has been accepted downstream.

Top module: `useq_top`

## Requirements
- R1: During and after a synchronous active-low reset, `out_valid` is 0, `req_ready` is 1 and `dec_stall` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `out_valid` presents the group stored at `req_entry`.
- R3: `req_ready` is 0 from the cycle after a request is taken until the cycle after the last group is accepted. A request held on `req_valid` during that time is not taken and does not disturb the flow in progress.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_uops`, `out_slot_vld` and `out_last` hold their values and the flow does not advance.
- R5: Slot 0 sits in `out_uops[3:0]`, slot 1 in [7:4] and slot 2 in [11:8]. Valid slots are packed from slot 0 upward. An invalid slot carries code 0. The uop codes are NOP=0, LOAD=1, STORE=2, ADD=3, SUB=4, INC=5, XOR=6, AND=7, MJCC=8, STA=9, STD=10.
- R6: `out_last` marks the final group of a flow. After that group is accepted, `out_valid` is 0 in the next cycle.
- R7: The repeated-move flow at entry 4 with count N>0 produces these groups: {ADD}, then N repetitions of {LOAD,STORE,INC} followed by {MJCC}, then {XOR} with last set.
- R8: The repeated-move flow with count 0 produces only {ADD} and then {XOR} with last set.
- R9: `dec_stall` is 1 in exactly the cycles in which `out_valid` is 1.
- R10: The legacy flow at entry 8 is a single last group {ADD,AND} with slot 2 invalid.
- R11: The bulk flow at entry 0 produces three full groups: {STA,STD,SUB}, {STA,STD,ADD}, and {STORE,STORE,LOAD} with last set.
- R12: An entry address holding no flow word produces a single group with no valid slot and last set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Flow request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_entry | input | 4 | Micro-ROM entry address of the flow |
| req_count | input | CNT_W | Repeat count for looping flows |
| out_valid | output | 1 | Uop group present |
| out_ready | input | 1 | Downstream takes the group |
| out_uops | output | 12 | Three uop codes, slot 0 lowest |
| out_slot_vld | output | 3 | Valid bit per slot |
| out_last | output | 1 | Final group of the flow |
| dec_stall | output | 1 | Holds off the regular decoders |

## Verification
The assertions watch the behaviour that holds on every cycle:
- the group is held while backpressured;
- `req_ready` and `out_valid` are never high together;
- valid slots are contiguous from slot 0;
- a taken request is followed by a valid group with the stall raised;
- `out_valid` falls after the last group.

The bench's scenarios cover the parts that depend on flow contents and the repeat count. These are the exact group sequences for each entry, the zero-count skip, the iteration count of the loop, and the empty group at an unused address. A cycle-by-cycle queue model checks them under full throughput and under intermittent backpressure.

// File: rtl/useq_pkg.sv
// Package: shared formats for the microcode sequencer.
// It holds the ROM word layout, the uop codes, the jump conditions and the flow entry points.
package useq_pkg;
    localparam int SLOTS  = 3;
    localparam int UOP_W  = 4;
    localparam int ROM_AW = 4;
    localparam int GRP_W  = SLOTS * UOP_W;

    typedef enum logic [UOP_W-1:0] {
        OP_NOP   = 4'd0,
        OP_LOAD  = 4'd1,
        OP_STORE = 4'd2,
        OP_ADD   = 4'd3,
        OP_SUB   = 4'd4,
        OP_INC   = 4'd5,
        OP_XOR   = 4'd6,
        OP_AND   = 4'd7,
        OP_MJCC  = 4'd8,
        OP_STA   = 4'd9,
        OP_STD   = 4'd10
    } uop_op_e;

    // Jump condition attached to a ROM word
    typedef enum logic [1:0] {
        JC_NONE    = 2'd0,
        JC_IF_ZERO = 2'd1,   // jump when the repeat counter is zero
        JC_LOOP    = 2'd2    // decrement the counter, jump while iterations remain
    } jcond_e;

    typedef struct packed {
        logic [GRP_W-1:0]  uops;
        logic [SLOTS-1:0]  vld;
        logic              last;
        jcond_e            cond;
        logic [ROM_AW-1:0] target;
    } rom_word_t;

    localparam logic [ROM_AW-1:0] ENTRY_BULK   = 4'd0;
    localparam logic [ROM_AW-1:0] ENTRY_REPMOV = 4'd4;
    localparam logic [ROM_AW-1:0] ENTRY_LEGACY = 4'd8;
endpackage

// File: rtl/useq_rom.sv
// Module: combinational micro-ROM.
// It returns the word stored at an address. Invalid slots carry OP_NOP.
// An address that holds no flow returns an empty group marked last, so a stray entry address still ends its flow.
module useq_rom
    import useq_pkg::*;
(
    input  logic [ROM_AW-1:0] addr,
    output rom_word_t         word
);
    // Assemble one ROM word from its fields
    function automatic rom_word_t mk(uop_op_e s0, uop_op_e s1, uop_op_e s2,
                                     logic [SLOTS-1:0] v, logic lst,
                                     jcond_e c, logic [ROM_AW-1:0] t);
        rom_word_t w;
        w.uops   = {s2, s1, s0};
        w.vld    = v;
        w.last   = lst;
        w.cond   = c;
        w.target = t;
        return w;
    endfunction

    // Table lookup of the flow contents
    always_comb begin
        case (addr)
            4'd0:    word = mk(OP_STA,   OP_STD,   OP_SUB,  3'b111, 1'b0, JC_NONE,    4'd0);
            4'd1:    word = mk(OP_STA,   OP_STD,   OP_ADD,  3'b111, 1'b0, JC_NONE,    4'd0);
            4'd2:    word = mk(OP_STORE, OP_STORE, OP_LOAD, 3'b111, 1'b1, JC_NONE,    4'd0);
            4'd4:    word = mk(OP_ADD,   OP_NOP,   OP_NOP,  3'b001, 1'b0, JC_IF_ZERO, 4'd7);
            4'd5:    word = mk(OP_LOAD,  OP_STORE, OP_INC,  3'b111, 1'b0, JC_NONE,    4'd0);
            4'd6:    word = mk(OP_MJCC,  OP_NOP,   OP_NOP,  3'b001, 1'b0, JC_LOOP,    4'd5);
            4'd7:    word = mk(OP_XOR,   OP_NOP,   OP_NOP,  3'b001, 1'b1, JC_NONE,    4'd0);
            4'd8:    word = mk(OP_ADD,   OP_AND,   OP_NOP,  3'b011, 1'b1, JC_NONE,    4'd0);
            default: word = mk(OP_NOP,   OP_NOP,   OP_NOP,  3'b000, 1'b1, JC_NONE,    4'd0);
        endcase
    end
endmodule

// File: rtl/useq_loop_ctr.sv
// Module: repeat down-counter and micro-jump condition evaluation.
// The counter is loaded when a request is taken.
// It decrements on each accepted loop word while it is non-zero.
// Assumes a loop word is never reached with a zero count; the zero guard skips the body.
module useq_loop_ctr
    import useq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  jcond_e           cond,
    output logic             take
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // Load on a new request, count down on each accepted loop word
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (step && cond == JC_LOOP && cnt != '0)
            cnt <= cnt - ONE;
    end

    // Jump decision for the word currently presented
    always_comb begin
        case (cond)
            JC_IF_ZERO: take = (cnt == '0);
            JC_LOOP:    take = (cnt > ONE);
            default:    take = 1'b0;
        endcase
    end
endmodule

// File: rtl/useq_ctrl.sv
// Module: flow state and micro-program counter.
// It enters the busy state on a taken request.
// On each accepted group it advances to the jump target or to the next address.
// It returns to idle when the last group is accepted.
module useq_ctrl
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_fire,
    input  logic [ROM_AW-1:0] req_entry,
    input  logic              grp_fire,
    input  logic              grp_last,
    input  logic              take,
    input  logic [ROM_AW-1:0] target,
    output logic              busy,
    output logic [ROM_AW-1:0] pc
);
    // Busy flag: set on a taken request, cleared when the last group is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (req_fire)
            busy <= 1'b1;
        else if (grp_fire && grp_last)
            busy <= 1'b0;
    end

    // Program counter: load the entry, then step or jump on each accepted group
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (req_fire)
            pc <= req_entry;
        else if (grp_fire && !grp_last)
            pc <= take ? target : pc + ROM_AW'(1);
    end
endmodule

// File: rtl/useq_top.sv
// Module: microcode ROM sequencer top.
// It takes a flow request and issues one three-slot uop group per cycle under valid/ready.
// It stalls the regular decoders while a flow is active.
// Assumes the request fields stay stable while req_valid is high.
module useq_top
    import useq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ROM_AW-1:0] req_entry,
    input  logic [CNT_W-1:0]  req_count,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [GRP_W-1:0]  out_uops,
    output logic [SLOTS-1:0]  out_slot_vld,
    output logic              out_last,
    output logic              dec_stall
);
    logic              busy;
    logic [ROM_AW-1:0] pc;
    rom_word_t         word;
    logic              take;
    logic              req_fire;
    logic              grp_fire;

    assign req_fire = req_valid && !busy;
    assign grp_fire = busy && out_ready;

    useq_rom u_rom (
        .addr (pc),
        .word (word)
    );

    useq_loop_ctr #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (req_fire),
        .load_val (req_count),
        .step     (grp_fire),
        .cond     (word.cond),
        .take     (take)
    );

    useq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fire  (req_fire),
        .req_entry (req_entry),
        .grp_fire  (grp_fire),
        .grp_last  (word.last),
        .take      (take),
        .target    (word.target),
        .busy      (busy),
        .pc        (pc)
    );

    // Per-slot output gating: an invalid slot always shows NOP
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign out_uops[s*UOP_W +: UOP_W] = word.vld[s] ? word.uops[s*UOP_W +: UOP_W] : OP_NOP;
    end

    assign out_slot_vld = word.vld;
    assign out_last     = word.last;
    assign out_valid    = busy;
    assign req_ready    = !busy;
    assign dec_stall    = busy;
endmodule

// File: rtl/useq_checker.sv
// Module: property checker for useq_top, attached through bind.
// It observes only the ports of the top module.
module useq_checker
    import useq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [CNT_W-1:0]  req_count,
    input logic              out_valid,
    input logic              out_ready,
    input logic [GRP_W-1:0]  out_uops,
    input logic [SLOTS-1:0]  out_slot_vld,
    input logic              out_last,
    input logic              dec_stall
);
    // R1: a reset cycle leaves the block idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && req_ready && !dec_stall));

    // R2 and R9: a taken request yields a presented group with the decoders stalled
    assert_req_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (out_valid && dec_stall));

    // R3: never idle-ready while a group is presented
    assert_ready_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);

    // R4: a backpressured group is held
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_uops)
                                       && $stable(out_slot_vld) && $stable(out_last)));

    // R5: valid slots are packed from slot 0 upward
    assert_slot_pack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_slot_vld & (out_slot_vld + SLOTS'(1))) == '0));

    // R6: the output drops after the last group is accepted
    assert_last_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

bind useq_top useq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_count    (req_count),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_uops     (out_uops),
    .out_slot_vld (out_slot_vld),
    .out_last     (out_last),
    .dec_stall    (dec_stall)
);

// File: tb/tb_useq_top.sv
// Bench for useq_top.
// A behavioural queue model holds the expected groups of each flow, built from the requirements.
// It is compared with the ports on every falling edge.
module tb_useq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_entry = '0;
    logic [7:0]  req_count = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [11:0] out_uops;
    logic [2:0]  out_slot_vld;
    logic        out_last;
    logic        dec_stall;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit choppy = 1'b0;
    bit model_on = 1'b0;
    string tag = "R2";
    logic [15:0] exp_q[$];      // {last, vld[2:0], s2, s1, s0}

    always #10 clk = ~clk;      // 50 MHz

    useq_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_entry(req_entry), .req_count(req_count), .out_valid(out_valid),
        .out_ready(out_ready), .out_uops(out_uops), .out_slot_vld(out_slot_vld),
        .out_last(out_last), .dec_stall(dec_stall)
    );

    function automatic logic [15:0] grp(int s0, int s1, int s2, logic [2:0] v, logic l);
        return {l, v, 4'(s2), 4'(s1), 4'(s0)};
    endfunction

    // Expected flow contents per requirement (codes from R5)
    task automatic push_flow(int entry, int count);
        case (entry)
            0: begin   // R11
                exp_q.push_back(grp(9, 10, 4, 3'b111, 0));
                exp_q.push_back(grp(9, 10, 3, 3'b111, 0));
                exp_q.push_back(grp(2, 2, 1, 3'b111, 1));
            end
            4: begin   // R7 / R8
                exp_q.push_back(grp(3, 0, 0, 3'b001, 0));
                for (int i = 0; i < count; i++) begin
                    exp_q.push_back(grp(1, 2, 5, 3'b111, 0));
                    exp_q.push_back(grp(8, 0, 0, 3'b001, 0));
                end
                exp_q.push_back(grp(6, 0, 0, 3'b001, 1));
            end
            8: exp_q.push_back(grp(3, 7, 0, 3'b011, 1));   // R10
            default: exp_q.push_back(grp(0, 0, 0, 3'b000, 1));   // R12
        endcase
    endtask

    task automatic check(string r, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", r, act, exp, cyc);
        end
    endtask

    // Per-cycle compare, then advance the model across the coming rising edge
    always @(negedge clk) begin
        cyc++;
        if (model_on) begin
            logic busy_exp;
            busy_exp = exp_q.size() != 0;
            check("R2/R6", 16'(out_valid), 16'(busy_exp));
            check("R3", 16'(req_ready), 16'(!busy_exp));
            check("R9", 16'(dec_stall), 16'(busy_exp));
            if (busy_exp && out_valid)
                check(out_ready ? tag : "R4", {out_last, out_slot_vld, out_uops}, exp_q[0]);
            if (busy_exp && out_ready)
                void'(exp_q.pop_front());
            else if (!busy_exp && req_valid)
                push_flow(int'(req_entry), int'(req_count));
        end
    end

    // Downstream ready pattern
    always @(posedge clk) begin
        #1 out_ready = choppy ? (cyc % 3 != 0) : 1'b1;
    end

    task automatic run_flow(int entry, int count, string r);
        bit acc;
        tag = r;
        @(posedge clk); #2;
        req_valid = 1'b1;
        req_entry = 4'(entry);
        req_count = 8'(count);
        do begin
            @(negedge clk);
            acc = req_ready;
        end while (!acc);
        @(posedge clk); #2;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {13'd0, out_valid, req_ready, dec_stall}, 16'b010);
        @(posedge clk); #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1", {13'd0, out_valid, req_ready, dec_stall}, 16'b010);
        model_on = 1'b1;

        run_flow(8, 0, "R10");
        run_flow(0, 0, "R11");
        run_flow(4, 3, "R7");
        run_flow(4, 0, "R8");
        run_flow(4, 1, "R7");
        run_flow(12, 5, "R12");
        choppy = 1'b1;
        run_flow(4, 2, "R7");
        run_flow(0, 0, "R11");
        choppy = 1'b0;

        // R3: a second request held during a flow waits and leaves the flow intact
        tag = "R3";
        @(posedge clk); #2;
        req_valid = 1'b1; req_entry = 4'd4; req_count = 8'd20;
        @(negedge clk);
        @(posedge clk); #2;
        req_entry = 4'd8; req_count = 8'd0;   // held request while busy
        begin
            bit idle;
            do begin @(negedge clk); idle = req_ready; end while (!idle);
        end
        @(posedge clk); #2 req_valid = 1'b0;
        repeat (2) @(negedge clk);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 100000);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule